// File: doc/BRIEF.md
# Link Interface Start-Up Sequencer

This block brings one direction of a source-synchronous packet link out of power-up and reset in a safe order. It runs on a free-running, always-on clock. It drives the PLL reset and an active-low core reset. It also reports a link mode that tells the rest of the interface whether to stay quiet, send its idle pattern, or run normally. A parameter selects the receiver or the transmitter flavour.

The PLL reset is released once a timed reference-clock settling interval has passed. The sequencer then waits for PLL lock. Next it waits until all secondary clocks report stable. After that it counts a minimum number of slowest-clock cycles, delivered as a one-cycle `slowTick` pulse in this clock domain, and only then releases the core reset.

After the core reset is released, a configuration-hold input keeps the link in its idle state. For a receiver, the idle state is the framing pattern on the status pins. For a transmitter, it is continuous training. While the hold is high, configuration inputs may change freely. They are captured once, when the hold drops. Normal operation starts only when the sequence is complete and an external trained/locked flag is high. A loss of PLL lock after it was gained sends the sequencer back to full reset.

Top module: `linkStartSeq`

## Requirements
- R1: While `porRst` is high, `pllReset` is 1, `coreRstN` is 0, `seqDone` is 0 and `linkMode` is 0 (held).
- R2: Counting from the cycle in which `porRst` is released, or the first cycle of a restart after lock loss, `pllReset` stays 1 for exactly SETTLE_CYCLES cycles and then goes to 0.
- R3: After `pllReset` falls, `coreRstN` stays 0 until `pllLocked` has been seen high. `coreRstN` is never 1 while `pllReset` is 1.
- R4: `coreRstN` rises only after a cycle in which every bit of `clkStable` was 1. If any bit drops before the core reset is released, the slow-clock count starts over.
- R5: `coreRstN` goes to 1 one cycle after the SLOW_MIN-th `slowTick` pulse seen with all clocks stable, and no earlier.
- R6: Receiver flavour: `frameStatus` is 2'b11 whenever `linkMode` is not normal, including all of core reset, and 2'b00 in normal mode.
- R7: Transmitter flavour: `trainReq` is 1 whenever `coreRstN` is 1 and `linkMode` is not normal, and 0 otherwise. `frameStatus` is always 2'b00.
- R8: While `cfgHold` is 1 and the core reset is released, `seqDone` is 0 from the next cycle on and `linkMode` is 1 (training/framing).
- R9: `cfgOut` takes the value of `cfgIn` from the cycle in which `cfgHold` drops with the core released, visible one cycle later. At all other times it keeps its value.
- R10: `seqDone` is 1 once the core reset is released and `cfgHold` is low. `linkMode` is 2 (normal) exactly when `seqDone` and `linkTrained` are both 1; otherwise, with the core released, it is 1.
- R11: When `pllLocked` is low after lock was gained, the next cycle shows full reset (`pllReset` 1, `coreRstN` 0, `seqDone` 0, `linkMode` 0), and the whole sequence restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| porRst | input | 1 | Power-on reset, active high, asynchronous |
| pllLocked | input | 1 | PLL lock indication |
| clkStable | input | NUM_CLKS | One stable flag per secondary clock |
| slowTick | input | 1 | One-cycle pulse per cycle of the slowest clock |
| cfgHold | input | 1 | Configuration hold request |
| linkTrained | input | 1 | External trained/locked flag |
| cfgIn | input | CFG_W | Configuration parameters to capture |
| pllReset | output | 1 | PLL reset, active high |
| coreRstN | output | 1 | Core reset, active low |
| seqDone | output | 1 | Sequence complete, hold released |
| linkMode | output | 2 | 0 held, 1 training/framing, 2 normal |
| frameStatus | output | 2 | Receiver status override (2'b11 framing) |
| trainReq | output | 1 | Transmitter training request |
| cfgOut | output | CFG_W | Captured configuration |

## Verification
The bench builds two instances side by side, one receiver and one transmitter, driven by the same inputs. Both use SETTLE_CYCLES=20, SLOW_MIN=4, three secondary clocks and an 8-bit configuration word. The short settle time makes it practical to count the exact PLL-reset length on every restart across several lock-loss cycles. The small tick count lets the bench place the release edge against each individual tick, and also drop a clock flag in the middle of the count. With both flavours present, the framing override and the training request are compared against each other in every phase.

// File: rtl/linkStartSeqPkg.sv
package linkStartSeqPkg;

  typedef enum logic [2:0] {
    ST_PLLRST   = 3'd0,
    ST_LOCKWAIT = 3'd1,
    ST_CLKWAIT  = 3'd2,
    ST_SLOWCNT  = 3'd3,
    ST_CONFIG   = 3'd4,
    ST_RUN      = 3'd5
  } seqState_t;

  localparam logic [1:0] MODE_HELD   = 2'd0;
  localparam logic [1:0] MODE_TRAIN  = 2'd1;
  localparam logic [1:0] MODE_NORMAL = 2'd2;

  localparam logic [1:0] FRAME_PATTERN = 2'b11;
  localparam logic [1:0] FRAME_FREE    = 2'b00;

  typedef struct packed {
    logic settleInc;
    logic settleClr;
    logic slowInc;
    logic slowClr;
    logic cfgCapture;
  } seqStrobe_t;

endpackage

// File: rtl/linkStartSeqPath.sv
module linkStartSeqPath
  import linkStartSeqPkg::*;
#(
  parameter int SETTLE_CYCLES = 1000,
  parameter int SLOW_MIN      = 4,
  parameter int CFG_W         = 8
) (
  input  logic             clk,
  input  logic             porRst,
  input  seqStrobe_t       strobe,
  input  logic [CFG_W-1:0] cfgIn,
  output logic             settleDone,
  output logic             slowDone,
  output logic [CFG_W-1:0] cfgOut
);

  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam int SLOW_W   = $clog2(SLOW_MIN + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_CYCLES - 1);
  localparam logic [SLOW_W-1:0]   SLOW_LAST   = SLOW_W'(SLOW_MIN - 1);

  logic [SETTLE_W-1:0] settleCnt;
  logic [SLOW_W-1:0]   slowCnt;

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                settleCnt <= '0;
    else if (strobe.settleClr) settleCnt <= '0;
    else if (strobe.settleInc) settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)              slowCnt <= '0;
    else if (strobe.slowClr) slowCnt <= '0;
    else if (strobe.slowInc) slowCnt <= slowCnt + 1'b1;
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                 cfgOut <= '0;
    else if (strobe.cfgCapture) cfgOut <= cfgIn;
  end

  assign settleDone = (settleCnt == SETTLE_LAST);
  assign slowDone   = (slowCnt == SLOW_LAST);

endmodule

// File: rtl/linkStartSeqCtrl.sv
module linkStartSeqCtrl
  import linkStartSeqPkg::*;
#(
  parameter bit IS_RX    = 1'b1,
  parameter int NUM_CLKS = 3
) (
  input  logic                clk,
  input  logic                porRst,
  input  logic                pllLocked,
  input  logic [NUM_CLKS-1:0] clkStable,
  input  logic                slowTick,
  input  logic                cfgHold,
  input  logic                linkTrained,
  input  logic                settleDone,
  input  logic                slowDone,
  output seqStrobe_t          strobe,
  output logic                pllReset,
  output logic                coreRstN,
  output logic                seqDone,
  output logic [1:0]          linkMode,
  output logic [1:0]          frameStatus,
  output logic                trainReq
);

  seqState_t state, nextState;
  logic allStable, lockLost;

  assign allStable = &clkStable;
  assign lockLost  = !pllLocked &&
                     (state inside {ST_CLKWAIT, ST_SLOWCNT, ST_CONFIG, ST_RUN});

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_PLLRST: begin
        strobe.settleInc = 1'b1;
        if (settleDone) nextState = ST_LOCKWAIT;
      end
      ST_LOCKWAIT: if (pllLocked) nextState = ST_CLKWAIT;
      ST_CLKWAIT: begin
        strobe.slowClr = 1'b1;
        if (allStable) nextState = ST_SLOWCNT;
      end
      ST_SLOWCNT: begin
        if (!allStable) nextState = ST_CLKWAIT;
        else if (slowTick) begin
          if (slowDone) nextState = ST_CONFIG;
          else          strobe.slowInc = 1'b1;
        end
      end
      ST_CONFIG: if (!cfgHold) begin
        nextState         = ST_RUN;
        strobe.cfgCapture = 1'b1;
      end
      ST_RUN: if (cfgHold) nextState = ST_CONFIG;
      default: nextState = ST_PLLRST;
    endcase
    if (state != ST_PLLRST) strobe.settleClr = 1'b1;
    if (lockLost) begin
      nextState         = ST_PLLRST;
      strobe.cfgCapture = 1'b0;
    end
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) state <= ST_PLLRST;
    else        state <= nextState;
  end

  assign pllReset = (state == ST_PLLRST);
  assign coreRstN = (state == ST_CONFIG) || (state == ST_RUN);
  assign seqDone  = (state == ST_RUN);

  always_comb begin
    if (!coreRstN)                   linkMode = MODE_HELD;
    else if (seqDone && linkTrained) linkMode = MODE_NORMAL;
    else                             linkMode = MODE_TRAIN;
  end

  generate
    if (IS_RX) begin : g_rxFlavour
      assign frameStatus = (linkMode == MODE_NORMAL) ? FRAME_FREE : FRAME_PATTERN;
      assign trainReq    = 1'b0;
    end else begin : g_txFlavour
      assign frameStatus = FRAME_FREE;
      assign trainReq    = (linkMode == MODE_TRAIN);
    end
  endgenerate

endmodule

// File: rtl/linkStartSeq.sv
module linkStartSeq
  import linkStartSeqPkg::*;
#(
  parameter bit IS_RX         = 1'b1,
  parameter int SETTLE_CYCLES = 1000,
  parameter int SLOW_MIN      = 4,
  parameter int NUM_CLKS      = 3,
  parameter int CFG_W         = 8
) (
  input  logic                clk,
  input  logic                porRst,
  input  logic                pllLocked,
  input  logic [NUM_CLKS-1:0] clkStable,
  input  logic                slowTick,
  input  logic                cfgHold,
  input  logic                linkTrained,
  input  logic [CFG_W-1:0]    cfgIn,
  output logic                pllReset,
  output logic                coreRstN,
  output logic                seqDone,
  output logic [1:0]          linkMode,
  output logic [1:0]          frameStatus,
  output logic                trainReq,
  output logic [CFG_W-1:0]    cfgOut
);

  seqStrobe_t strobe;
  logic settleDone, slowDone;

  linkStartSeqCtrl #(.IS_RX(IS_RX), .NUM_CLKS(NUM_CLKS)) u_ctrl (
    .clk(clk), .porRst(porRst), .pllLocked(pllLocked), .clkStable(clkStable),
    .slowTick(slowTick), .cfgHold(cfgHold), .linkTrained(linkTrained),
    .settleDone(settleDone), .slowDone(slowDone), .strobe(strobe),
    .pllReset(pllReset), .coreRstN(coreRstN), .seqDone(seqDone),
    .linkMode(linkMode), .frameStatus(frameStatus), .trainReq(trainReq)
  );

  linkStartSeqPath #(.SETTLE_CYCLES(SETTLE_CYCLES), .SLOW_MIN(SLOW_MIN),
                     .CFG_W(CFG_W)) u_path (
    .clk(clk), .porRst(porRst), .strobe(strobe), .cfgIn(cfgIn),
    .settleDone(settleDone), .slowDone(slowDone), .cfgOut(cfgOut)
  );

endmodule

// File: rtl/linkStartSeqChk.sv
module linkStartSeqChk #(
  parameter bit IS_RX    = 1'b1,
  parameter int NUM_CLKS = 3,
  parameter int CFG_W    = 8
) (
  input logic                clk,
  input logic                porRst,
  input logic                pllLocked,
  input logic [NUM_CLKS-1:0] clkStable,
  input logic                slowTick,
  input logic                cfgHold,
  input logic                linkTrained,
  input logic                pllReset,
  input logic                coreRstN,
  input logic                seqDone,
  input logic [1:0]          linkMode,
  input logic [1:0]          frameStatus,
  input logic                trainReq,
  input logic [CFG_W-1:0]    cfgOut
);

  p_order_r3: assert property (@(posedge clk) disable iff (porRst)
    coreRstN |-> !pllReset);

  p_stable_r4: assert property (@(posedge clk) disable iff (porRst)
    $rose(coreRstN) |-> $past(&clkStable));

  p_tick_r5: assert property (@(posedge clk) disable iff (porRst)
    $rose(coreRstN) |-> $past(slowTick));

  p_hold_r8: assert property (@(posedge clk) disable iff (porRst)
    (coreRstN && cfgHold) |=> !seqDone);

  p_capture_r9: assert property (@(posedge clk) disable iff (porRst)
    !$stable(cfgOut) |-> $rose(seqDone));

  p_normal_r10: assert property (@(posedge clk) disable iff (porRst)
    (linkMode == 2'd2) |-> (seqDone && linkTrained));

  p_lockloss_r11: assert property (@(posedge clk) disable iff (porRst)
    (coreRstN && !pllLocked) |=> (pllReset && !coreRstN));

  generate
    if (IS_RX) begin : g_rxChk
      p_frame_r6: assert property (@(posedge clk) disable iff (porRst)
        !coreRstN |-> (frameStatus == 2'b11));
    end else begin : g_txChk
      p_train_r7: assert property (@(posedge clk) disable iff (porRst)
        (coreRstN && linkMode != 2'd2) |-> trainReq);
    end
  endgenerate

endmodule

bind linkStartSeq linkStartSeqChk #(.IS_RX(IS_RX), .NUM_CLKS(NUM_CLKS), .CFG_W(CFG_W)) i_chk (
  .clk(clk), .porRst(porRst), .pllLocked(pllLocked), .clkStable(clkStable),
  .slowTick(slowTick), .cfgHold(cfgHold), .linkTrained(linkTrained),
  .pllReset(pllReset), .coreRstN(coreRstN), .seqDone(seqDone),
  .linkMode(linkMode), .frameStatus(frameStatus), .trainReq(trainReq),
  .cfgOut(cfgOut)
);

// File: tb/test_linkStartSeq.sv
`timescale 1ns/1ps
module test_linkStartSeq;

  localparam int SETTLE = 20;
  localparam int SLOWN  = 4;
  localparam int NCLK   = 3;
  localparam int CW     = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic porRst, pllLocked, slowTick, cfgHold, linkTrained;
  logic [NCLK-1:0] clkStable;
  logic [CW-1:0]   cfgIn;

  logic rxPllReset, rxCoreRstN, rxSeqDone, rxTrainReq;
  logic [1:0] rxMode, rxFrame;
  logic [CW-1:0] rxCfgOut;
  logic txPllReset, txCoreRstN, txSeqDone, txTrainReq;
  logic [1:0] txMode, txFrame;
  logic [CW-1:0] txCfgOut;

  int nChecks = 0;
  int nFail   = 0;
  int expCfg  = 0;

  linkStartSeq #(.IS_RX(1'b1), .SETTLE_CYCLES(SETTLE), .SLOW_MIN(SLOWN),
                 .NUM_CLKS(NCLK), .CFG_W(CW)) i_linkStartSeq (
    .clk(clk), .porRst(porRst), .pllLocked(pllLocked), .clkStable(clkStable),
    .slowTick(slowTick), .cfgHold(cfgHold), .linkTrained(linkTrained), .cfgIn(cfgIn),
    .pllReset(rxPllReset), .coreRstN(rxCoreRstN), .seqDone(rxSeqDone),
    .linkMode(rxMode), .frameStatus(rxFrame), .trainReq(rxTrainReq), .cfgOut(rxCfgOut));

  linkStartSeq #(.IS_RX(1'b0), .SETTLE_CYCLES(SETTLE), .SLOW_MIN(SLOWN),
                 .NUM_CLKS(NCLK), .CFG_W(CW)) i_linkStartSeqTx (
    .clk(clk), .porRst(porRst), .pllLocked(pllLocked), .clkStable(clkStable),
    .slowTick(slowTick), .cfgHold(cfgHold), .linkTrained(linkTrained), .cfgIn(cfgIn),
    .pllReset(txPllReset), .coreRstN(txCoreRstN), .seqDone(txSeqDone),
    .linkMode(txMode), .frameStatus(txFrame), .trainReq(txTrainReq), .cfgOut(txCfgOut));

  // Bench model of the mode encoding: 0 held, 1 training/framing, 2 normal
  function automatic int expMode(bit core, bit done, bit trained);
    if (!core) return 0;
    if (done && trained) return 2;
    return 1;
  endfunction
  function automatic int expRxFrame(int mode);
    return (mode == 2) ? 0 : 3;
  endfunction
  function automatic int expTxTrain(int mode);
    return (mode == 1) ? 1 : 0;
  endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // Checks both flavours' mode-dependent outputs against the model
  task automatic chkModes(input string tag, input bit core, input bit done, input bit trained);
    int m;
    m = expMode(core, done, trained);
    chkEq({tag, " mode R10"}, rxMode, m);
    chkEq({tag, " mode tx R10"}, txMode, m);
    chkEq({tag, " rx frame R6"}, rxFrame, expRxFrame(m));
    chkEq({tag, " tx train R7"}, txTrainReq, expTxTrain(m));
    chkEq({tag, " tx frame R7"}, txFrame, 0);
    chkEq({tag, " rx train R6"}, rxTrainReq, 0);
  endtask

  // Called at the first negedge of a reset phase; counts cycles pllReset stays high
  task automatic runSettle;
    int n;
    n = 0;
    while (rxPllReset && n < 10 * SETTLE) begin
      chkEq("R3 core held during settle", rxCoreRstN, 0);
      n++;
      @(negedge clk);
    end
    chkEq("R2 pll reset length", n, SETTLE);
    chkEq("R2 tx pll reset low", txPllReset, 0);
  endtask

  task automatic pulseTick;
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic bringUp(input bit glitch);
    int start;
    repeat ($urandom % 20 + 3) begin
      @(negedge clk);
      chkEq("R3 no core before lock", rxCoreRstN, 0);
      chkEq("R3 pll reset stays low", rxPllReset, 0);
    end
    pllLocked = 1'b1;
    start = $urandom % NCLK;
    for (int i = 0; i < NCLK; i++) begin
      repeat ($urandom % 4 + 1) @(negedge clk);
      chkEq("R4 core held until clocks stable", rxCoreRstN, 0);
      clkStable[(start + i) % NCLK] = 1'b1;
    end
    @(negedge clk);
    if (glitch) begin
      pulseTick();
      pulseTick();
      clkStable[start] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      clkStable[start] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chkEq("R4 count restart after drop", rxCoreRstN, 0);
    end
    for (int k = 1; k <= SLOWN; k++) begin
      pulseTick();
      chkEq("R5 core release on last tick", rxCoreRstN, (k == SLOWN) ? 1 : 0);
      chkEq("R5 tx core release", txCoreRstN, (k == SLOWN) ? 1 : 0);
      if (k != SLOWN) repeat ($urandom % 3) @(negedge clk);
    end
    chkEq("R3 pll reset with core out", rxPllReset, 0);
    repeat ($urandom % 5 + 2) begin
      cfgIn = CW'($urandom);
      @(negedge clk);
      chkEq("R8 no done during hold", rxSeqDone, 0);
      chkModes("R8 hold", 1'b1, 1'b0, linkTrained);
      chkEq("R9 cfg stable during hold", rxCfgOut, expCfg);
    end
    cfgIn   = CW'($urandom);
    expCfg  = cfgIn;
    cfgHold = 1'b0;
    @(negedge clk);
    chkEq("R9 cfg captured", rxCfgOut, expCfg);
    chkEq("R9 tx cfg captured", txCfgOut, expCfg);
    chkEq("R10 done after hold", rxSeqDone, 1);
    chkModes("R10 untrained", 1'b1, 1'b1, 1'b0);
    cfgIn = ~cfgIn;
    repeat (3) @(negedge clk);
    chkEq("R9 cfg held after capture", rxCfgOut, expCfg);
    linkTrained = 1'b1;
    @(negedge clk);
    chkModes("R10 trained", 1'b1, 1'b1, 1'b1);
    cfgHold = 1'b1;
    @(negedge clk);
    chkEq("R8 re-hold clears done", rxSeqDone, 0);
    chkModes("R8 re-hold", 1'b1, 1'b0, 1'b1);
    cfgIn   = CW'($urandom);
    expCfg  = cfgIn;
    cfgHold = 1'b0;
    @(negedge clk);
    chkEq("R9 cfg recaptured", rxCfgOut, expCfg);
    chkModes("R10 normal again", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic loseLock;
    repeat ($urandom % 6) @(negedge clk);
    pllLocked   = 1'b0;
    clkStable   = '0;
    cfgHold     = 1'b1;
    linkTrained = 1'b0;
    @(negedge clk);
    chkEq("R11 pll reset on lock loss", rxPllReset, 1);
    chkEq("R11 core reset on lock loss", rxCoreRstN, 0);
    chkEq("R11 done cleared", rxSeqDone, 0);
    chkModes("R11 reset", 1'b0, 1'b0, 1'b0);
    chkEq("R11 cfg kept", rxCfgOut, expCfg);
    runSettle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (R1..all) actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    porRst = 1'b1; pllLocked = 1'b0; clkStable = '0; slowTick = 1'b0;
    cfgHold = 1'b1; linkTrained = 1'b0; cfgIn = '0;
    repeat (3) @(negedge clk);
    chkEq("R1 pll reset at por", rxPllReset, 1);
    chkEq("R1 core reset at por", rxCoreRstN, 0);
    chkEq("R1 done at por", rxSeqDone, 0);
    chkEq("R1 tx pll reset at por", txPllReset, 1);
    chkModes("R1 por", 1'b0, 1'b0, 1'b0);
    porRst = 1'b0;
    runSettle();
    for (int iter = 0; iter < 4; iter++) begin
      bringUp(iter == 0 || iter == 2);
      loseLock();
    end
    finishRun();
  end

endmodule